// File: doc/BRIEF.md
# Clock-Strobed Transmit-Only Byte Streamer

This block sends the full contents of a 128-byte memory as an endless serial bit stream on a shared open-drain data line. It needs no host commands. A slow external clock paces the stream. The system clock samples that clock into a one-cycle rise strobe, and the block moves one bit for each such strobe. The block reads the memory through a plain asynchronous read port: it drives an address, and the byte at that address is expected back in the same cycle.

After reset the line is left undriven for a fixed number of strobes, so the receiver has time to synchronize. From then on, every strobe puts out the next bit, most significant bit first. Each byte is followed by one released filler bit. When address 127 has been sent, the stream carries on from address 0 with no gap.

A separate mode controller owns the line. Its enable input lets the block drive the line or forces it released. Its restart strobe returns the stream to the first bit of address 0.

Top module: `ddc_stream_tx`

## Requirements
- R1: While reset is held, and on the cycle after it is released, `sdaPullLow` is 0 and `memAddr` is 0.
- R2: After reset, the first 9 enabled rise strobes leave `sdaPullLow` at 0. The 10th enabled strobe drives bit 7 of the byte at address 0.
- R3: Each enabled strobe after the sync phase drives the next bit of the current byte, from bit 7 down to bit 0. A 0 bit sets `sdaPullLow` to 1 and a 1 bit sets it to 0.
- R4: The 9th strobe of every byte frame is a filler bit with `sdaPullLow` at 0. The strobe after it drives bit 7 of the next address.
- R5: After the byte at address 127 and its filler bit, `memAddr` returns to 0 and the stream continues with bit 7 of address 0.
- R6: While `enable` is 0, `sdaPullLow` is 0 in that same cycle, and rise strobes have no effect. When `enable` returns to 1, the line shows the bit it held before, and the next strobe continues from the frozen bit and address.
- R7: A restart strobe sets `memAddr` to 0 and releases the line on the next cycle. The next enabled rise strobe drives bit 7 of address 0, without a new sync phase. A restart in the same cycle as a rise strobe wins.
- R8: `memAddr` changes only on the cycle after a rise strobe or a restart strobe.
- R9: With `enable` held at 1, `sdaPullLow` changes only on the cycle after a rise strobe or a restart strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| vclkRise | input | 1 | One-cycle strobe marking a rising edge of the stream clock |
| enable | input | 1 | Permission from the mode controller to drive the line |
| restart | input | 1 | Restart the stream at address 0, bit 7 |
| memData | input | 8 | Byte read from the memory at `memAddr` |
| memAddr | output | 7 | Read address of the byte being sent |
| sdaPullLow | output | 1 | 1 pulls the open-drain data line low |

## Verification
The bench rebuilds bytes from the line and compares them with its own memory model across the 127-to-0 wrap. A design that wraps too early, or skips the filler bit, shifts every later byte and is caught there.

It checks that the 9th strobe after reset still shows a released line, because a sync counter that is off by one would push out bit 7 one strobe early. It also checks that a restart is followed at once by data with no second sync phase; an extra sync phase would misread the first byte. During a disabled window the bench sends strobes and then re-enables, to confirm the same bit is still held and the stream picks up where it stopped. A design that counts strobes while disabled would have moved on.

// File: rtl/ddc_stream_pkg.sv
package ddc_stream_pkg;
  localparam int DATA_W     = 8;
  localparam int FRAME_BITS = DATA_W + 1;
  localparam int BIT_W      = $clog2(FRAME_BITS);

  typedef struct packed {
    logic             emit;
    logic             clear;
    logic             nullBit;
    logic [BIT_W-1:0] bitSel;
  } txStrobe_t;
endpackage

// File: rtl/ddc_stream_ctrl.sv
module ddc_stream_ctrl
  import ddc_stream_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_CYCLES = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              vclkRise,
  input  logic              enable,
  input  logic              restart,
  output logic [ADDR_W-1:0] addr,
  output txStrobe_t         strobe
);
  localparam int SYNC_W   = $clog2(SYNC_CYCLES + 1);
  localparam int LAST_BIT = FRAME_BITS - 1;

  logic [SYNC_W-1:0] syncCnt;
  logic              syncDone;
  logic [BIT_W-1:0]  bitCnt;
  logic              step;
  logic              syncEnd;
  logic              emit;
  logic              frameEnd;

  assign step     = vclkRise & enable & ~restart;
  assign syncEnd  = (syncCnt == SYNC_W'(SYNC_CYCLES));
  assign emit     = step & (syncDone | syncEnd);
  assign frameEnd = (bitCnt == BIT_W'(LAST_BIT));

  // Sync phase: count released strobes until the first data bit is due.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncCnt  <= '0;
      syncDone <= 1'b0;
    end else if (step && !syncDone) begin
      if (syncEnd) syncDone <= 1'b1;
      else         syncCnt  <= syncCnt + SYNC_W'(1);
    end
  end

  // Bit position in the frame and byte address (wraps through its width).
  always_ff @(posedge clk) begin
    if (!rstN || restart) begin
      bitCnt <= '0;
      addr   <= '0;
    end else if (emit) begin
      if (frameEnd) begin
        bitCnt <= '0;
        addr   <= addr + ADDR_W'(1);
      end else begin
        bitCnt <= bitCnt + BIT_W'(1);
      end
    end
  end

  always_comb begin
    strobe.emit    = emit;
    strobe.clear   = restart;
    strobe.nullBit = frameEnd;
    strobe.bitSel  = bitCnt;
  end
endmodule

// File: rtl/ddc_stream_dp.sv
module ddc_stream_dp
  import ddc_stream_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  txStrobe_t         strobe,
  input  logic [DATA_W-1:0] memData,
  output logic              sdaPullLow
);
  logic [DATA_W-1:0] shifted;
  logic              driveLow;

  assign shifted = memData << strobe.bitSel;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      driveLow <= 1'b0;
    end else if (strobe.emit) begin
      driveLow <= strobe.nullBit ? 1'b0 : ~shifted[DATA_W-1];
    end
  end

  assign sdaPullLow = driveLow & enable;
endmodule

// File: rtl/ddc_stream_tx.sv
module ddc_stream_tx
  import ddc_stream_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_CYCLES = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              vclkRise,
  input  logic              enable,
  input  logic              restart,
  input  logic [DATA_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              sdaPullLow
);
  txStrobe_t strobe;

  ddc_stream_ctrl #(.ADDR_W(ADDR_W), .SYNC_CYCLES(SYNC_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .vclkRise(vclkRise), .enable(enable),
    .restart(restart), .addr(memAddr), .strobe(strobe)
  );

  ddc_stream_dp u_dp (
    .clk(clk), .rstN(rstN), .enable(enable), .strobe(strobe),
    .memData(memData), .sdaPullLow(sdaPullLow)
  );
endmodule

// File: rtl/ddc_stream_tx_chk.sv
module ddc_stream_tx_chk #(
  parameter int ADDR_W      = 7,
  parameter int SYNC_CYCLES = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              vclkRise,
  input logic              enable,
  input logic              restart,
  input logic [ADDR_W-1:0] memAddr,
  input logic              sdaPullLow
);
  localparam int CNT_W = $clog2(SYNC_CYCLES + 2);
  logic [CNT_W-1:0] riseCnt;

  always_ff @(posedge clk) begin
    if (!rstN) riseCnt <= '0;
    else if (vclkRise && enable && !restart && riseCnt <= CNT_W'(SYNC_CYCLES))
      riseCnt <= riseCnt + CNT_W'(1);
  end

  p_sync_release_r2: assert property (@(posedge clk) disable iff (!rstN)
    (riseCnt <= CNT_W'(SYNC_CYCLES)) |-> !sdaPullLow);

  p_disabled_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !sdaPullLow);

  p_restart_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> !sdaPullLow);

  p_restart_addr_r7: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> (memAddr == '0));

  p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!vclkRise && !restart) |=> $stable(memAddr));

  p_out_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!vclkRise && !restart && enable) |=> (!enable || $stable(sdaPullLow)));
endmodule

bind ddc_stream_tx ddc_stream_tx_chk #(.ADDR_W(ADDR_W), .SYNC_CYCLES(SYNC_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .vclkRise(vclkRise), .enable(enable),
  .restart(restart), .memAddr(memAddr), .sdaPullLow(sdaPullLow)
);

// File: tb/tb_ddc_stream_tx.sv
module tb_ddc_stream_tx;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;
  // {strobe count since reset, expected sdaPullLow}; memory byte = addr ^ 8'hB4
  localparam logic [16:0] VEC [NVEC] = '{
    {16'd9,  1'b0}, {16'd10, 1'b0}, {16'd11, 1'b1}, {16'd12, 1'b0},
    {16'd13, 1'b0}, {16'd14, 1'b1}, {16'd15, 1'b0}, {16'd16, 1'b1},
    {16'd17, 1'b1}, {16'd18, 1'b0}, {16'd19, 1'b0}, {16'd20, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       vclkRise = 1'b0;
  logic       enable = 1'b1;
  logic       restart = 1'b0;
  logic [7:0] memData;
  logic [6:0] memAddr;
  logic       sdaPullLow;
  int         checks = 0;
  int         errors = 0;
  int         pulses = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign memData = {1'b0, memAddr} ^ 8'hB4;

  ddc_stream_tx dut (
    .clk(clk), .rstN(rstN), .vclkRise(vclkRise), .enable(enable),
    .restart(restart), .memData(memData), .memAddr(memAddr), .sdaPullLow(sdaPullLow)
  );

  function automatic logic [7:0] model(int a);
    return 8'(a % 128) ^ 8'hB4;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse();
    @(negedge clk) vclkRise = 1'b1;
    @(negedge clk) vclkRise = 1'b0;
    @(negedge clk);
    pulses++;
  endtask

  task automatic streamCheck(int nBytes, int startAddr, string req);
    for (int b = 0; b < nBytes; b++) begin
      logic [7:0] got;
      check({req, " addr"}, memAddr, (startAddr + b) % 128);
      for (int i = 7; i >= 0; i--) begin
        pulse();
        got[i] = ~sdaPullLow;
      end
      check({req, " byte"}, got, model(startAddr + b));
      pulse();
      check({req, " R4 filler"}, sdaPullLow, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset out", sdaPullLow, 0);
    check("R1 reset addr", memAddr, 0);
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);
    check("R1 post-reset out", sdaPullLow, 0);

    // R2/R3/R4: sync phase then MSB-first bits of bytes 0 and 1
    for (int v = 0; v < NVEC; v++) begin
      while (pulses < int'(VEC[v][16:1])) pulse();
      check(v == 0 ? "R2 sync" : "R3 bit", sdaPullLow, VEC[v][0]);
    end

    // R6: disable freezes position and releases line
    @(negedge clk) enable = 1'b0;
    #1 check("R6 released", sdaPullLow, 0);
    for (int k = 0; k < 5; k++) pulse();
    check("R6 still released", sdaPullLow, 0);
    @(negedge clk) enable = 1'b1;
    #1 check("R6 bit held", sdaPullLow, 1);
    check("R6 addr held", memAddr, 1);
    pulse(); check("R6 resume", sdaPullLow, 0);
    pulse(); check("R6 resume", sdaPullLow, 0);
    pulse(); check("R6 resume", sdaPullLow, 1);

    // R7: restart beats a simultaneous strobe, no sync repeat
    @(negedge clk) begin restart = 1'b1; vclkRise = 1'b1; end
    @(negedge clk) begin restart = 1'b0; vclkRise = 1'b0; end
    check("R7 released", sdaPullLow, 0);
    check("R7 addr", memAddr, 0);
    repeat (3) @(negedge clk);
    check("R9 hold", sdaPullLow, 0);

    // R5/R3/R4/R7/R8: full stream across the wrap
    streamCheck(130, 0, "R5 R7 stream");
    check("R5 wrap addr", memAddr, 2);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule